// File: doc/BRIEF.md
# PHY Management Register Model

This block is a register-level stand-in for one Ethernet PHY as seen through a MAC's station-management registers. A host writes three 32-bit registers through a word-aligned write port with a one-cycle strobe. The select register names a PHY address and a register number. The data register carries a value to store in the PHY. The command register starts a read, and the value read lands in a 16-bit result output.

Behind these registers sits a bank of thirty-two 16-bit PHY registers. The bank comes out of reset with defined contents. The control register has two special bits. A soft reset reloads the bank, and an autonegotiation request completes at once. Both bits clear themselves. A link-status input is synchronised and drives the link and autonegotiation-done flags in the PHY status register. The PHY answers only at one fixed address. The serial management waveform is not generated.

Top module: `mii_phy_regmodel`

## Requirements
- R1: After reset, `mgmt_rdata` is 0x0000. The PHY bank reads back as follows: register 0 (control) = 0x1140, register 1 (status) = 0x7948 while the link is down, register 2 = 0x0022, register 3 = 0x1550, register 4 = 0x01E1, register 5 = 0xCDE1, and every other register = 0x0000.
- R2: Byte offsets decoded from `wr_addr` are: 0x0 select register, 0x4 data register, 0x8 command register. Address bits [1:0] are ignored. In the select register, bits [4:0] hold the PHY register number and bits [12:8] hold the PHY address.
- R3: A command write with bit 0 = 1 loads the selected register's value into `mgmt_rdata` one clock after the strobe. A command write with bit 0 = 0 changes nothing.
- R4: A data-register write while PHY address 1 is selected stores `wr_data[15:0]` into the selected PHY register. Control-register writes are the exception; see R6 and R7.
- R5: For any PHY address other than 1, a read returns 0xFFFF and a data-register write leaves the bank unchanged.
- R6: A write to control register 0 with bit 15 set reloads every register with its R1 value, using the current link state. The written data is then stored into register 0 with bit 15 cleared.
- R7: A write to control register 0 with bit 12 set stores the data with bit 12 cleared and sets bit 5 (autonegotiation done) of status register 1.
- R8: Bits 2 (link up) and 5 of status register 1 both take the value of `link_in` at the second rising edge after `link_in` changes. The link value is sampled through two flip-flops.
- R9: `mgmt_rdata` holds its value in every cycle without a read command.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| wr_en | input | 1 | One-cycle register write strobe |
| wr_addr | input | ADDR_W | Byte address of the register written |
| wr_data | input | 32 | Write data |
| link_in | input | 1 | Asynchronous link-up indication |
| mgmt_rdata | output | 16 | Result of the last management read |

## Verification
The bench goes after the boundaries between the special control bits and ordinary stores. A design that forgets to clear the soft-reset bit would keep reloading the bank. A design that reloads without the current link would leave the link flags stale after a reset. Foreign-address traffic is checked by reading back the register that a wrongly accepted write would have clobbered, and by expecting 0xFFFF from the read. The link path is checked for its exact two-clock latency and for the case where the autonegotiation-done flag is raised by a request while the link is down. A command write with bit 0 clear must leave the result untouched.

// File: rtl/mii_phy_regmodel.sv
module mii_phy_regmodel #(
  parameter int ADDR_W   = 4,
  parameter int DATA_W   = 16,
  parameter int PHY_ADDR = 1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic [ADDR_W-1:0] wr_addr,
  input  logic [31:0]       wr_data,
  input  logic              link_in,
  output logic [DATA_W-1:0] mgmt_rdata
);
  localparam int NREG  = 32;
  localparam int SEL_W = ADDR_W - 2;
  localparam logic [SEL_W-1:0] OFF_SEL  = SEL_W'(0);
  localparam logic [SEL_W-1:0] OFF_DATA = SEL_W'(1);
  localparam logic [SEL_W-1:0] OFF_CMD  = SEL_W'(2);
  localparam int B_SRST = 15;
  localparam int B_ANEN = 12;
  localparam int B_ANOK = 5;
  localparam int B_LINK = 2;

  logic [4:0]        phy_sel, reg_sel;
  logic              link_s1, link_s2;
  logic [DATA_W-1:0] bank    [NREG];
  logic [DATA_W-1:0] bank_nx [NREG];
  logic [DATA_W-1:0] ctl_val;

  wire [SEL_W-1:0]  wsel    = wr_addr[ADDR_W-1:2];
  wire              phy_hit = (phy_sel == 5'(PHY_ADDR));
  wire              sel_wr  = wr_en && (wsel == OFF_SEL);
  wire              dat_wr  = wr_en && (wsel == OFF_DATA);
  wire              rd_fire = wr_en && (wsel == OFF_CMD) && wr_data[0];
  wire              link_ev = (link_s1 != link_s2);
  wire [DATA_W-1:0] rd_val  = bank[reg_sel];
  wire              unused_bits = ^{wr_data[31:16], wr_addr[1:0]};

  function automatic logic [DATA_W-1:0] dflt(input int idx, input logic lk);
    case (idx)
      0:       dflt = 16'h1140;
      1:       dflt = 16'h7948 | (lk ? 16'h0024 : 16'h0000);
      2:       dflt = 16'h0022;
      3:       dflt = 16'h1550;
      4:       dflt = 16'h01E1;
      5:       dflt = 16'hCDE1;
      default: dflt = '0;
    endcase
  endfunction

  always_comb begin
    for (int i = 0; i < NREG; i++) bank_nx[i] = bank[i];
    ctl_val = wr_data[DATA_W-1:0];
    ctl_val[B_SRST] = 1'b0;
    ctl_val[B_ANEN] = 1'b0;
    if (dat_wr && phy_hit) begin
      if (reg_sel == 5'd0) begin
        if (wr_data[B_SRST])
          for (int i = 0; i < NREG; i++) bank_nx[i] = dflt(i, link_s1);
        if (wr_data[B_ANEN]) bank_nx[1][B_ANOK] = 1'b1;
        bank_nx[0] = ctl_val;
      end else begin
        bank_nx[reg_sel] = wr_data[DATA_W-1:0];
      end
    end
    if (link_ev) begin
      bank_nx[1][B_LINK] = link_s1;
      bank_nx[1][B_ANOK] = link_s1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      link_s1 <= 1'b0;
      link_s2 <= 1'b0;
    end else begin
      link_s1 <= link_in;
      link_s2 <= link_s1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      phy_sel <= '0;
      reg_sel <= '0;
    end else if (sel_wr) begin
      phy_sel <= wr_data[12:8];
      reg_sel <= wr_data[4:0];
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) mgmt_rdata <= '0;
    else if (rd_fire) mgmt_rdata <= phy_hit ? rd_val : {DATA_W{1'b1}};
  end

  generate
    for (genvar g = 0; g < NREG; g++) begin : g_bank
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) bank[g] <= dflt(g, 1'b0);
        else        bank[g] <= bank_nx[g];
      end
    end
  endgenerate

  p_hold_r9: assert property (@(posedge clk) disable iff (!rst_n)
    !rd_fire |=> $stable(mgmt_rdata));

  p_read_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_fire && phy_hit) |=> mgmt_rdata == $past(rd_val));

  p_foreign_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_fire && !phy_hit) |=> mgmt_rdata == 16'hFFFF);

  p_srst_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (dat_wr && phy_hit && reg_sel == 5'd0 && wr_data[B_SRST])
      |=> (!bank[0][B_SRST] && bank[2] == 16'h0022 && bank[5] == 16'hCDE1));

  p_anen_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (dat_wr && phy_hit && reg_sel == 5'd0 && wr_data[B_ANEN] && !link_ev)
      |=> (bank[1][B_ANOK] && !bank[0][B_ANEN]));

  p_link_r8: assert property (@(posedge clk) disable iff (!rst_n)
    link_ev |=> (bank[1][B_LINK] == $past(link_s1) && bank[1][B_ANOK] == $past(link_s1)));
endmodule

// File: tb/mii_phy_regmodel_bench.sv
module mii_phy_regmodel_bench;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        wr_en = 1'b0;
  logic [3:0]  wr_addr = '0;
  logic [31:0] wr_data = '0;
  logic        link_in = 1'b0;
  logic [15:0] mgmt_rdata;
  int checks = 0;
  int errors = 0;
  logic done = 1'b0;

  always #2 clk = ~clk;

  mii_phy_regmodel u_mii_phy_regmodel (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr),
    .wr_data(wr_data), .link_in(link_in), .mgmt_rdata(mgmt_rdata));

  // behavioural reference: state updated per edge from the requirement text
  logic [15:0] m_bank [32];
  logic [15:0] m_sts;
  int          m_phy, m_reg;
  logic        lk_hist [$];

  function automatic logic [15:0] m_dflt(int i, logic lk);
    logic [15:0] t [6] = '{16'h1140, 16'h7948, 16'h0022, 16'h1550, 16'h01E1, 16'hCDE1};
    if (i > 5) return 16'h0000;
    if (i == 1 && lk) return 16'h796C;
    return t[i];
  endfunction

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < 32; i++) m_bank[i] = m_dflt(i, 1'b0);
      m_sts = 16'h0; m_phy = 0; m_reg = 0;
      lk_hist = '{1'b0, 1'b0};
    end else begin
      logic newer, older;
      newer = lk_hist[0]; older = lk_hist[1];
      if (wr_en) begin
        case (wr_addr[3:2])
          2'd0: begin m_phy = int'(wr_data[12:8]); m_reg = int'(wr_data[4:0]); end
          2'd1: if (m_phy == 1) begin
            if (m_reg == 0) begin
              logic [15:0] v;
              if (wr_data[15]) for (int i = 0; i < 32; i++) m_bank[i] = m_dflt(i, newer);
              v = wr_data[15:0] & 16'h6FFF;
              if (wr_data[12]) m_bank[1][5] = 1'b1;
              m_bank[0] = v;
            end else m_bank[m_reg] = wr_data[15:0];
          end
          2'd2: if (wr_data[0]) m_sts = (m_phy == 1) ? m_bank[m_reg] : 16'hFFFF;
          default: ;
        endcase
      end
      if (newer != older) begin m_bank[1][2] = newer; m_bank[1][5] = newer; end
      lk_hist.push_front(link_in);
      void'(lk_hist.pop_back());
    end
  end

  always @(negedge clk) if (rst_n && !done) begin
    checks++;
    if (mgmt_rdata !== m_sts) begin
      errors++;
      $display("FAIL model R3/R9: actual=%h expected=%h", mgmt_rdata, m_sts);
    end
  end

  task automatic chk(string req, logic [15:0] act, logic [15:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic wr(logic [3:0] a, logic [31:0] d);
    wr_en = 1'b1; wr_addr = a; wr_data = d;
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic rd(int phy, int rg, output logic [15:0] v);
    wr(4'h0, (32'(phy) << 8) | 32'(rg));
    wr(4'h8, 32'h1);
    v = mgmt_rdata;
  endtask

  initial begin
    #400000;
    errors++; checks++;
    $display("FAIL watchdog: actual=timeout expected=finish");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    logic [15:0] v;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    chk("R1 rdata reset", mgmt_rdata, 16'h0000);
    rd(1, 0, v); chk("R1 ctl", v, 16'h1140);
    rd(1, 1, v); chk("R1 status", v, 16'h7948);
    rd(1, 2, v); chk("R1 id1", v, 16'h0022);
    rd(1, 3, v); chk("R1 id2", v, 16'h1550);
    rd(1, 4, v); chk("R1 adv", v, 16'h01E1);
    rd(1, 5, v); chk("R1 lpa", v, 16'hCDE1);
    rd(1, 9, v); chk("R1 other", v, 16'h0000);
    // R8 two-clock latency
    link_in = 1'b1;
    @(negedge clk);
    rd(1, 1, v); chk("R8 link up", v, 16'h796C);
    // R4 and R2 (low address bits ignored)
    wr(4'h0, 32'h0000_0104);
    wr(4'h5, 32'hFFFF_ABCD);
    rd(1, 4, v); chk("R4 store", v, 16'hABCD);
    // R5 foreign address
    rd(2, 4, v); chk("R5 foreign read", v, 16'hFFFF);
    wr(4'h0, 32'h0000_0204);
    wr(4'h4, 32'h0000_1234);
    rd(1, 4, v); chk("R5 write ignored", v, 16'hABCD);
    // R3 command with bit0 clear
    rd(1, 3, v);
    wr(4'h0, 32'h0000_0102);
    wr(4'h8, 32'h0000_0002);
    chk("R3 no read", mgmt_rdata, 16'h1550);
    // R8 link down, R7 autoneg
    link_in = 1'b0;
    repeat (3) @(negedge clk);
    rd(1, 1, v); chk("R8 link down", v, 16'h7948);
    wr(4'h0, 32'h0000_0100);
    wr(4'h4, 32'h0000_1000);
    rd(1, 0, v); chk("R7 ctl cleared", v, 16'h0000);
    rd(1, 1, v); chk("R7 an done", v, 16'h7968);
    // R6 soft reset
    wr(4'h0, 32'h0000_0100);
    wr(4'h4, 32'h0000_8000);
    rd(1, 0, v); chk("R6 ctl", v, 16'h0000);
    rd(1, 4, v); chk("R6 reload adv", v, 16'h01E1);
    rd(1, 1, v); chk("R6 reload status", v, 16'h7948);
    link_in = 1'b1;
    repeat (3) @(negedge clk);
    wr(4'h0, 32'h0000_0100);
    wr(4'h4, 32'h0000_9100);
    rd(1, 0, v); chk("R6 R7 ctl", v, 16'h0100);
    rd(1, 1, v); chk("R6 status with link", v, 16'h796C);
    // raw status store
    wr(4'h0, 32'h0000_0101);
    wr(4'h4, 32'h0000_0024);
    rd(1, 1, v); chk("R4 status store", v, 16'h0024);
    repeat (2) @(negedge clk);
    chk("R9 hold", mgmt_rdata, 16'h0024);
    done = 1'b1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule